// File: doc/BRIEF.md
# Multiprocessor-Mode Serial Transmitter

This block sends asynchronous serial frames on a single line. Software writes a byte into a holding register through a small register write port. The transmitter moves that byte into its own shift register, marks the holding register empty, and shifts the frame out. Each frame carries one extra flag bit after the data bits. A receiver uses that bit to tell an address frame from a data frame.

The line advances one bit on each pulse of an external baud-enable input. While the last data bit and the flag bit go out, software may already have refilled the holding register. At the first stop bit the transmitter checks whether it has. If it has, the next frame follows the last stop bit with no idle gap. If it has not, the transmitter raises a transmission-end flag and leaves the line at mark after the stop bits.

Two level interrupt requests follow the buffer-empty and transmission-end flags, each gated by its own enable. Configuration is written at its own address. A frame takes its configuration when its start bit begins, so a change made during a frame applies from the next frame.

Top module: `mpx_serial_tx`

## Requirements
- R1: After reset txd is 1, buf_empty is 1, tx_end is 1, and irq_empty and irq_end are 0.
- R2: A write to address 0 stores wr_data in the holding register. In the next cycle buf_empty is 0 and tx_end is 0.
- R3: On a baud_tick while the line is idle and buf_empty is 0, the holding byte is moved to the shift register and buf_empty becomes 1. txd drops to 0 for the start bit. Every bit of a frame lasts exactly one baud_tick interval.
- R4: The frame order on txd is fixed. It is one 0 start bit, then the data bits least significant bit first, then the flag bit, then the stop bits of 1. The frame settings are written at address 1. Bit 0 = 1 selects 7 data bits and bit 0 = 0 selects 8. Bit 1 = 1 selects two stop bits and bit 1 = 0 selects one. Bit 2 is the value of the flag bit.
- R5: buf_empty is sampled on the baud_tick that starts the first stop bit. If it is 0 there, the next byte is moved into the shift register and buf_empty becomes 1. The next start bit then follows the last stop bit directly, and tx_end stays 0.
- R6: If buf_empty is 1 when the first stop bit starts, tx_end becomes 1. After the stop bits txd stays at 1 until a later start bit.
- R7: irq_empty equals the AND of interrupt-enable bit 0 and buf_empty, one cycle later. The enables are written at address 2.
- R8: irq_end equals the AND of interrupt-enable bit 1 and tx_end, one cycle later.
- R9: The frame settings are latched when a frame's start bit begins. A write to address 1 during a frame changes only the frames that start afterwards.
- R10: A data write may land in the same cycle as a move from the holding register to the shift register. In that case the frame being started uses the old byte, the new byte is kept, and buf_empty stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register select: 0 data, 1 frame settings, 2 interrupt enables |
| wr_data | input | DATA_W | Write data |
| baud_tick | input | 1 | One-cycle bit-period enable |
| txd | output | 1 | Serial output line |
| buf_empty | output | 1 | Holding register empty flag |
| tx_end | output | 1 | Transmission-end flag |
| irq_empty | output | 1 | Transmit-data-empty interrupt request |
| irq_end | output | 1 | Transmit-end interrupt request |

## Verification
Two functions can act in the same cycle. A software write to the holding register can land on the same clock edge at which the transmitter moves the previous byte into the shift register. The bench provokes this because it generates the baud enable itself: it places the write strobe exactly on a tick edge while an earlier byte is waiting. The result is judged in two ways. buf_empty must read 0 right after that edge, and the serial stream must carry the old byte followed directly by the new one with no gap.

// File: rtl/mpx_tx_pkg.sv
`timescale 1ns/1ps
package mpx_tx_pkg;

  // register map
  localparam int ADDR_DATA = 0;
  localparam int ADDR_CFG  = 1;
  localparam int ADDR_IE   = 2;

  // interrupt channel indices
  localparam int IRQ_EMPTY = 0;
  localparam int IRQ_END   = 1;
  localparam int IRQ_N     = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_FLAG,
    ST_STOP1,
    ST_STOP2
  } tx_state_e;

  // bit 2: flag bit value, bit 1: two stop bits, bit 0: short (7-bit) data
  typedef struct packed {
    logic flag_val;
    logic two_stop;
    logic short_len;
  } frame_cfg_t;

endpackage

// File: rtl/mpx_tx_regs.sv
`timescale 1ns/1ps
module mpx_tx_regs
  import mpx_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              xfer,
  input  logic              set_end,
  output logic [DATA_W-1:0] hold_q,
  output frame_cfg_t        cfg_q,
  output logic [IRQ_N-1:0]  ie_q,
  output logic              buf_empty,
  output logic              tx_end
);

  logic wr_data_sel;
  logic wr_cfg_sel;
  logic wr_ie_sel;

  always_comb begin
    wr_data_sel = wr_en && (wr_addr == ADDR_W'(ADDR_DATA));
    wr_cfg_sel  = wr_en && (wr_addr == ADDR_W'(ADDR_CFG));
    wr_ie_sel   = wr_en && (wr_addr == ADDR_W'(ADDR_IE));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= '0;
    end else if (wr_data_sel) begin
      hold_q <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
      ie_q  <= '0;
    end else begin
      if (wr_cfg_sel) cfg_q <= frame_cfg_t'(wr_data[2:0]);
      if (wr_ie_sel)  ie_q  <= wr_data[IRQ_N-1:0];
    end
  end

  // a software write takes priority over transmitter updates
  always_ff @(posedge clk) begin
    if (rst) begin
      buf_empty <= 1'b1;
      tx_end    <= 1'b1;
    end else if (wr_data_sel) begin
      buf_empty <= 1'b0;
      tx_end    <= 1'b0;
    end else begin
      if (xfer)    buf_empty <= 1'b1;
      if (set_end) tx_end    <= 1'b1;
    end
  end

endmodule

// File: rtl/mpx_tx_seq.sv
`timescale 1ns/1ps
module mpx_tx_seq
  import mpx_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              buf_empty,
  input  logic [DATA_W-1:0] hold_q,
  input  frame_cfg_t        cfg_in,
  output logic              xfer,
  output logic              set_end,
  output logic              txd
);

  localparam int CNT_W = $clog2(DATA_W + 1);

  tx_state_e         state;
  logic [DATA_W-1:0] shreg;
  logic [CNT_W-1:0]  bit_cnt;
  logic [CNT_W-1:0]  nbits;
  frame_cfg_t        cur;
  logic              chain;
  logic              last_stop;
  logic              txd_q;

  always_comb begin
    nbits     = cur.short_len ? CNT_W'(DATA_W - 1) : CNT_W'(DATA_W);
    last_stop = (state == ST_STOP2) || (state == ST_STOP1 && !cur.two_stop);
    xfer      = tick && !buf_empty && (state == ST_IDLE || state == ST_FLAG);
    set_end   = tick && buf_empty && (state == ST_FLAG);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      txd_q   <= 1'b1;
      shreg   <= '0;
      bit_cnt <= '0;
      cur     <= '0;
      chain   <= 1'b0;
    end else if (tick) begin
      case (state)
        ST_IDLE: begin
          if (!buf_empty) begin
            shreg <= hold_q;
            cur   <= cfg_in;
            txd_q <= 1'b0;
            state <= ST_START;
          end else begin
            txd_q <= 1'b1;
          end
        end
        ST_START: begin
          txd_q   <= shreg[0];
          shreg   <= shreg >> 1;
          bit_cnt <= CNT_W'(1);
          state   <= ST_DATA;
        end
        ST_DATA: begin
          if (bit_cnt == nbits) begin
            txd_q <= cur.flag_val;
            state <= ST_FLAG;
          end else begin
            txd_q   <= shreg[0];
            shreg   <= shreg >> 1;
            bit_cnt <= bit_cnt + 1'b1;
          end
        end
        ST_FLAG: begin
          txd_q <= 1'b1;
          state <= ST_STOP1;
          if (!buf_empty) begin
            shreg <= hold_q;
            chain <= 1'b1;
          end else begin
            chain <= 1'b0;
          end
        end
        ST_STOP1, ST_STOP2: begin
          if (!last_stop) begin
            txd_q <= 1'b1;
            state <= ST_STOP2;
          end else if (chain) begin
            cur   <= cfg_in;
            chain <= 1'b0;
            txd_q <= 1'b0;
            state <= ST_START;
          end else begin
            txd_q <= 1'b1;
            state <= ST_IDLE;
          end
        end
        default: begin
          txd_q <= 1'b1;
          state <= ST_IDLE;
        end
      endcase
    end
  end

  assign txd = txd_q;

endmodule

// File: rtl/mpx_tx_irq.sv
`timescale 1ns/1ps
module mpx_tx_irq #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] en,
  input  logic [N-1:0] flag,
  output logic [N-1:0] irq
);

  for (genvar i = 0; i < N; i++) begin : g_irq
    always_ff @(posedge clk) begin
      if (rst) irq[i] <= 1'b0;
      else     irq[i] <= en[i] & flag[i];
    end
  end

endmodule

// File: rtl/mpx_serial_tx.sv
`timescale 1ns/1ps
module mpx_serial_tx
  import mpx_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              baud_tick,
  output logic              txd,
  output logic              buf_empty,
  output logic              tx_end,
  output logic              irq_empty,
  output logic              irq_end
);

  logic [DATA_W-1:0] hold_q;
  frame_cfg_t        cfg_q;
  logic [IRQ_N-1:0]  ie_q;
  logic [IRQ_N-1:0]  irq_flags;
  logic [IRQ_N-1:0]  irq_q;
  logic              xfer;
  logic              set_end;

  mpx_tx_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) regs_i (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .xfer      (xfer),
    .set_end   (set_end),
    .hold_q    (hold_q),
    .cfg_q     (cfg_q),
    .ie_q      (ie_q),
    .buf_empty (buf_empty),
    .tx_end    (tx_end)
  );

  mpx_tx_seq #(.DATA_W(DATA_W)) seq_i (
    .clk       (clk),
    .rst       (rst),
    .tick      (baud_tick),
    .buf_empty (buf_empty),
    .hold_q    (hold_q),
    .cfg_in    (cfg_q),
    .xfer      (xfer),
    .set_end   (set_end),
    .txd       (txd)
  );

  always_comb begin
    irq_flags            = '0;
    irq_flags[IRQ_EMPTY] = buf_empty;
    irq_flags[IRQ_END]   = tx_end;
  end

  mpx_tx_irq #(.N(IRQ_N)) irq_i (
    .clk  (clk),
    .rst  (rst),
    .en   (ie_q),
    .flag (irq_flags),
    .irq  (irq_q)
  );

  assign irq_empty = irq_q[IRQ_EMPTY];
  assign irq_end   = irq_q[IRQ_END];

endmodule

// File: rtl/mpx_serial_tx_chk.sv
`timescale 1ns/1ps
module mpx_serial_tx_chk #(
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              buf_empty,
  input logic              tx_end,
  input logic              txd,
  input logic              xfer,
  input logic [1:0]        ie_q,
  input logic              irq_empty,
  input logic              irq_end
);

  logic past_ok;
  logic wr_dat;

  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  assign wr_dat = wr_en && (wr_addr == '0);

  a_r2_write_clears: assert property (@(posedge clk) disable iff (rst)
    wr_dat |=> (!buf_empty && !tx_end));

  a_r3_xfer_empties: assert property (@(posedge clk) disable iff (rst)
    (xfer && !wr_dat) |=> buf_empty);

  a_r10_write_wins: assert property (@(posedge clk) disable iff (rst)
    (xfer && wr_dat) |=> !buf_empty);

  a_r6_mark_hold: assert property (@(posedge clk) disable iff (rst)
    (past_ok && tx_end && buf_empty) |=> txd);

  a_r7_irq_empty: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (irq_empty == $past(ie_q[0] & buf_empty)));

  a_r8_irq_end: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (irq_end == $past(ie_q[1] & tx_end)));

endmodule

bind mpx_serial_tx mpx_serial_tx_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .buf_empty (buf_empty),
  .tx_end    (tx_end),
  .txd       (txd),
  .xfer      (xfer),
  .ie_q      (ie_q),
  .irq_empty (irq_empty),
  .irq_end   (irq_end)
);

// File: tb/mpx_serial_tx_tb_top.sv
`timescale 1ns/100ps
module mpx_serial_tx_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       baud_tick = 1'b0;
  logic       txd, buf_empty, tx_end, irq_empty, irq_end;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic rec [0:255];
  int   nrec = 0;
  logic expv [0:63];
  int   nexp = 0;
  int   tdiv = 0;

  mpx_serial_tx dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .baud_tick(baud_tick), .txd(txd), .buf_empty(buf_empty), .tx_end(tx_end),
    .irq_empty(irq_empty), .irq_end(irq_end)
  );

  always #2 clk = ~clk;

  // baud enable: one pulse every 4 clocks, changed at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      tdiv++;
      baud_tick = (tdiv % 4 == 0);
    end
  end

  // record one txd level per bit period
  initial begin
    forever begin
      @(posedge clk);
      if (baud_tick) begin
        #0.5;
        if (nrec < 256) begin
          rec[nrec] = txd;
          nrec++;
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #600000;
    checks++;
    fails++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    finish_run();
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #0.5;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic wait_pre_tick();
    while (!baud_tick) step();
  endtask

  task automatic wait_ticks(input int n);
    repeat (n * 4) step();
  endtask

  task automatic add_frame(input logic [7:0] d, input logic [2:0] c);
    int nb;
    nb = c[0] ? 7 : 8;
    expv[nexp] = 1'b0; nexp++;
    for (int i = 0; i < nb; i++) begin
      expv[nexp] = d[i]; nexp++;
    end
    expv[nexp] = c[2]; nexp++;
    expv[nexp] = 1'b1; nexp++;
    if (c[1]) begin
      expv[nexp] = 1'b1; nexp++;
    end
  endtask

  task automatic check_stream(input string req);
    int     f;
    bit     ok;
    longint a, e;
    f = -1;
    for (int i = 0; i < nrec; i++) begin
      if (f < 0 && rec[i] == 1'b0) f = i;
    end
    ok = (f >= 0) && (f + nexp + 2 <= nrec);
    a = 0; e = 0;
    if (ok) begin
      for (int i = 0; i < nexp + 2; i++) begin
        logic ev;
        ev = (i < nexp) ? expv[i] : 1'b1;
        if (rec[f+i] !== ev) ok = 1'b0;
        if (i < 60) begin
          a = (a << 1) | longint'(rec[f+i]);
          e = (e << 1) | longint'(ev);
        end
      end
    end
    chk(ok, req, a, e);
  endtask

  task automatic clear_streams();
    nrec = 0;
    nexp = 0;
  endtask

  initial begin
    logic [7:0] vals [5];
    vals[0] = 8'h00; vals[1] = 8'hFF; vals[2] = 8'hA5; vals[3] = 8'h5A; vals[4] = 8'h81;

    repeat (5) step();
    rst = 1'b0;
    step();

    // R1 reset state
    chk(txd == 1'b1, "R1 txd", txd, 1);
    chk(buf_empty == 1'b1, "R1 buf_empty", buf_empty, 1);
    chk(tx_end == 1'b1, "R1 tx_end", tx_end, 1);
    chk(irq_empty == 1'b0, "R1 irq_empty", irq_empty, 0);
    chk(irq_end == 1'b0, "R1 irq_end", irq_end, 0);

    // R4 / R3 / R6: sweep all frame settings and several bytes
    for (int c = 0; c < 8; c++) begin
      wr(2'd1, 8'(c));
      for (int v = 0; v < 5; v++) begin
        clear_streams();
        add_frame(vals[v], 3'(c));
        wr(2'd0, vals[v]);
        // R2 flags cleared by write
        chk(buf_empty == 1'b0 && tx_end == 1'b0, "R2 flags after write",
            {buf_empty, tx_end}, 0);
        wait_ticks(20);
        check_stream("R4 frame order");
        chk(tx_end == 1'b1, "R6 tx_end after frame", tx_end, 1);
        chk(buf_empty == 1'b1, "R3 buf_empty after move", buf_empty, 1);
        chk(txd == 1'b1, "R6 mark state", txd, 1);
      end
    end

    // R5 + R9: back-to-back frames with a settings change mid-frame
    clear_streams();
    wr(2'd1, 8'h00);
    add_frame(8'h5A, 3'b000);
    add_frame(8'hC3, 3'b111);
    wr(2'd0, 8'h5A);
    while (!buf_empty) step();
    wr(2'd0, 8'hC3);
    wr(2'd1, 8'h07);
    while (!buf_empty) step();
    chk(tx_end == 1'b0, "R5 tx_end held low on chained frame", tx_end, 0);
    wait_ticks(30);
    check_stream("R5 R9 chained stream");

    // R10: data write on the same edge as the move to the shift register
    clear_streams();
    wr(2'd1, 8'h00);
    add_frame(8'h96, 3'b000);
    add_frame(8'h0F, 3'b000);
    wait_pre_tick();
    step();
    wr(2'd0, 8'h96);
    wait_pre_tick();
    wr(2'd0, 8'h0F);
    chk(buf_empty == 1'b0, "R10 buf_empty after coincident write", buf_empty, 0);
    chk(txd == 1'b0, "R3 start bit began", txd, 0);
    wait_ticks(30);
    check_stream("R10 coincident stream");

    // R7 / R8 interrupt requests
    wr(2'd2, 8'h03);
    step();
    chk(irq_empty == 1'b1, "R7 irq_empty on", irq_empty, 1);
    chk(irq_end == 1'b1, "R8 irq_end on", irq_end, 1);
    wr(2'd0, 8'h33);
    step();
    chk(irq_empty == 1'b0, "R7 irq_empty drops on write", irq_empty, 0);
    chk(irq_end == 1'b0, "R8 irq_end drops on write", irq_end, 0);
    while (!buf_empty) step();
    step();
    chk(irq_empty == 1'b1, "R7 irq_empty after move", irq_empty, 1);
    chk(irq_end == 1'b0, "R8 irq_end mid-frame", irq_end, 0);
    wait_ticks(20);
    chk(irq_end == 1'b1, "R8 irq_end after frame", irq_end, 1);
    wr(2'd2, 8'h01);
    step();
    chk(irq_end == 1'b0, "R8 irq_end disabled", irq_end, 0);
    chk(irq_empty == 1'b1, "R7 irq_empty still enabled", irq_empty, 1);
    wr(2'd2, 8'h00);
    step();
    chk(irq_empty == 1'b0, "R7 irq_empty disabled", irq_empty, 0);

    finish_run();
  end

endmodule